// File: doc/BRIEF.md
# Masked Associative Lookup Store

This block is a small content-addressable store. Each of its entries keeps a key, a payload and an occupancy flag. A lookup request carries a probe key and a care mask. Every occupied entry is compared with the probe at the same moment, and key bits whose mask bit is 0 are ignored. The block reports whether nothing, exactly one entry or more than one entry matched. It returns the per-entry match vector and, when anything matched, the index and payload of the lowest-numbered matching entry.

Entries are not written by address. A write request looks for a vacant slot by searching on the occupancy flag, which is treated as an extra most-significant key bit. It stores the new key and payload in the lowest vacant slot and marks that slot occupied. If no slot is vacant, the write reports that the store is full and changes nothing. A release request names an entry by index and marks it vacant again. A synchronous reset marks every entry vacant.

Requests use a valid/ready handshake. Each accepted request produces a single-cycle response strobe on the following clock.

Top module: `cam_assoc_store`

## Requirements
- R1: After synchronous reset (`rst` high, active high) every entry is vacant, `rsp_valid` is low, and a lookup of any key returns the none status.
- R2: A lookup matches an occupied entry when the stored key and the probe key agree on every bit position where `req_mask` is 1; bits where the mask is 0 are don't-care.
- R3: For a lookup response, exactly one of `rsp_none`, `rsp_one` and `rsp_many` is high: none for zero matching entries, one for a single match, many for two or more. For other operations all three are low.
- R4: When a lookup finds at least one match, `rsp_index` is the lowest matching entry index and `rsp_data` is that entry's payload. When there is no match, `rsp_data` keeps its previous value.
- R5: A write (op code 1) stores the key and payload in the lowest-indexed vacant entry, marks it occupied, and reports that index on `rsp_index` with `rsp_full` low.
- R6: A write that finds no vacant entry raises `rsp_full` for the single response cycle and leaves every entry unchanged.
- R7: Vacant entries never match a lookup, whatever key and mask are applied.
- R8: A release (op code 2) marks the entry at `req_index` vacant. A later write may then reuse that entry.
- R9: `req_ready` is low while `rst` is high and high otherwise. Each accepted request (op 0 lookup, 1 write, 2 release, 3 no-op) gives `rsp_valid` high for exactly the next cycle, with `rsp_op` echoing the op code.
- R10: On a lookup response, bit i of `rsp_match` is 1 exactly when entry i matched. On other responses `rsp_match` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 lookup, 1 write, 2 release, 3 no-op |
| req_key | input | KEY_W | Probe key or key to store |
| req_mask | input | KEY_W | Care mask for lookup (1 = compare) |
| req_data | input | DATA_W | Payload to store |
| req_index | input | IDX_W | Entry to release |
| rsp_valid | output | 1 | Response strobe |
| rsp_op | output | 2 | Op code of the answered request |
| rsp_none | output | 1 | Lookup found no entry |
| rsp_one | output | 1 | Lookup found exactly one entry |
| rsp_many | output | 1 | Lookup found several entries |
| rsp_full | output | 1 | Write found no vacant entry |
| rsp_index | output | IDX_W | Selected lookup entry or written entry |
| rsp_match | output | ENTRIES | Registered per-entry match vector |
| rsp_data | output | DATA_W | Payload of the selected entry |

## Verification
On every cycle, the assertions check the one-cycle response timing, the exclusivity of the three lookup status bits, and the agreement between `rsp_index` and the match vector for single and multiple hits. They also check that no vacant entry appears in a match vector and that a full write leaves occupancy unchanged. Only the bench scenarios can show that masked comparison selects the correct entries and returns the correct payloads, that allocation picks the lowest vacant slot, and that a released slot is reused. The bench sweeps every key and mask of a small configuration against a model kept in the bench.

// File: rtl/cam_pkg.sv
`timescale 1ns/1ps
package cam_pkg;

  typedef enum logic [1:0] {
    OP_SEARCH = 2'd0,
    OP_WRITE  = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_NOP    = 2'd3
  } cam_op_e;

  typedef struct packed {
    logic none;
    logic one;
    logic many;
  } hit_status_t;

endpackage

// File: rtl/cam_entry_store.sv
`timescale 1ns/1ps
module cam_entry_store #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [KEY_W-1:0]          wr_key,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      clr_en,
  input  logic [IDX_W-1:0]          clr_idx,
  output logic [ENTRIES*KEY_W-1:0]  key_flat,
  output logic [ENTRIES*DATA_W-1:0] data_flat,
  output logic [ENTRIES-1:0]        busy
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic              busy_q;
    logic [KEY_W-1:0]  key_q;
    logic [DATA_W-1:0] data_q;
    logic              sel_wr;
    logic              sel_clr;

    assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(e));
    assign sel_clr = clr_en && (clr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_q <= 1'b0;
      end else if (sel_wr) begin
        busy_q <= 1'b1;
      end else if (sel_clr) begin
        busy_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_wr) begin
        key_q  <= wr_key;
        data_q <= wr_data;
      end
    end

    assign busy[e]                        = busy_q;
    assign key_flat[e*KEY_W +: KEY_W]     = key_q;
    assign data_flat[e*DATA_W +: DATA_W]  = data_q;
  end

endmodule

// File: rtl/cam_compare_plane.sv
`timescale 1ns/1ps
module cam_compare_plane #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 8
) (
  input  logic [ENTRIES*KEY_W-1:0] key_flat,
  input  logic [ENTRIES-1:0]       busy,
  input  logic [KEY_W-1:0]         probe_key,
  input  logic [KEY_W-1:0]         probe_mask,
  output logic [ENTRIES-1:0]       hit_vec,
  output logic [ENTRIES-1:0]       free_vec
);

  localparam int WORD_W = KEY_W + 1;

  // Extended word: occupancy flag on top of the key.
  function automatic logic word_hits(input logic [WORD_W-1:0] stored,
                                     input logic [WORD_W-1:0] probe,
                                     input logic [WORD_W-1:0] care);
    return ((stored ^ probe) & care) == '0;
  endfunction

  logic [WORD_W-1:0] lookup_probe;
  logic [WORD_W-1:0] lookup_care;
  logic [WORD_W-1:0] vacancy_probe;
  logic [WORD_W-1:0] vacancy_care;

  assign lookup_probe  = {1'b1, probe_key};
  assign lookup_care   = {1'b1, probe_mask};
  assign vacancy_probe = '0;
  assign vacancy_care  = {1'b1, {KEY_W{1'b0}}};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [WORD_W-1:0] word;
    assign word        = {busy[e], key_flat[e*KEY_W +: KEY_W]};
    assign hit_vec[e]  = word_hits(word, lookup_probe, lookup_care);
    assign free_vec[e] = word_hits(word, vacancy_probe, vacancy_care);
  end

endmodule

// File: rtl/cam_resolve.sv
`timescale 1ns/1ps
module cam_resolve
  import cam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] vec,
  output hit_status_t        status,
  output logic [IDX_W-1:0]   first_idx
);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  function automatic logic more_than_one(input logic [ENTRIES-1:0] v);
    return |(v & (v - ENTRIES'(1)));
  endfunction

  assign status.none = ~|vec;
  assign status.many = more_than_one(vec);
  assign status.one  = (|vec) & ~status.many;
  assign first_idx   = lowest_set(vec);

endmodule

// File: rtl/cam_assoc_store.sv
`timescale 1ns/1ps
module cam_assoc_store
  import cam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [KEY_W-1:0]   req_key,
  input  logic [KEY_W-1:0]   req_mask,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [IDX_W-1:0]   req_index,
  output logic               rsp_valid,
  output logic [1:0]         rsp_op,
  output logic               rsp_none,
  output logic               rsp_one,
  output logic               rsp_many,
  output logic               rsp_full,
  output logic [IDX_W-1:0]   rsp_index,
  output logic [ENTRIES-1:0] rsp_match,
  output logic [DATA_W-1:0]  rsp_data
);

  // Named internal events
  logic        accept;
  cam_op_e     op;
  logic        do_search;
  logic        do_write;
  logic        do_clear;
  logic        write_commit;
  logic        write_full;

  logic [ENTRIES*KEY_W-1:0]  key_flat;
  logic [ENTRIES*DATA_W-1:0] data_flat;
  logic [ENTRIES-1:0]        busy_vec;
  logic [ENTRIES-1:0]        hit_vec;
  logic [ENTRIES-1:0]        free_vec;
  hit_status_t               hit_st;
  hit_status_t               free_st;
  logic [IDX_W-1:0]          hit_idx;
  logic [IDX_W-1:0]          free_idx;
  logic [DATA_W-1:0]         hit_payload;

  assign req_ready    = !rst;
  assign accept       = req_valid && req_ready;
  assign op           = cam_op_e'(req_op);
  assign do_search    = accept && (op == OP_SEARCH);
  assign do_write     = accept && (op == OP_WRITE);
  assign do_clear     = accept && (op == OP_CLEAR);
  assign write_commit = do_write && !free_st.none;
  assign write_full   = do_write && free_st.none;

  cam_entry_store #(
    .ENTRIES(ENTRIES), .KEY_W(KEY_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (write_commit),
    .wr_idx   (free_idx),
    .wr_key   (req_key),
    .wr_data  (req_data),
    .clr_en   (do_clear),
    .clr_idx  (req_index),
    .key_flat (key_flat),
    .data_flat(data_flat),
    .busy     (busy_vec)
  );

  cam_compare_plane #(
    .ENTRIES(ENTRIES), .KEY_W(KEY_W)
  ) u_plane (
    .key_flat  (key_flat),
    .busy      (busy_vec),
    .probe_key (req_key),
    .probe_mask(req_mask),
    .hit_vec   (hit_vec),
    .free_vec  (free_vec)
  );

  cam_resolve #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_hit_res (
    .vec      (hit_vec),
    .status   (hit_st),
    .first_idx(hit_idx)
  );

  cam_resolve #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_free_res (
    .vec      (free_vec),
    .status   (free_st),
    .first_idx(free_idx)
  );

  assign hit_payload = data_flat[hit_idx*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_op    <= 2'd0;
      rsp_none  <= 1'b0;
      rsp_one   <= 1'b0;
      rsp_many  <= 1'b0;
      rsp_full  <= 1'b0;
      rsp_index <= '0;
      rsp_match <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_op    <= req_op;
      rsp_none  <= do_search && hit_st.none;
      rsp_one   <= do_search && hit_st.one;
      rsp_many  <= do_search && hit_st.many;
      rsp_full  <= write_full;
      rsp_match <= do_search ? hit_vec : '0;
      if (do_search) begin
        rsp_index <= hit_idx;
      end else if (write_commit) begin
        rsp_index <= free_idx;
      end else begin
        rsp_index <= '0;
      end
      if (do_search && !hit_st.none) begin
        rsp_data <= hit_payload;
      end
    end
  end

  // Response timing
  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);
  assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rsp_valid);

  // Lookup status exclusivity
  assert_status_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_op == OP_SEARCH) |-> $onehot({rsp_none, rsp_one, rsp_many}));
  assert_status_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_op != OP_SEARCH) |-> !(rsp_none || rsp_one || rsp_many));

  // Index agrees with match vector
  assert_single_index_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_one |-> rsp_match == (ENTRIES'(1) << rsp_index));
  assert_many_lowest_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_many |-> (rsp_match[rsp_index] &&
                  ((rsp_match & ((ENTRIES'(1) << rsp_index) - ENTRIES'(1))) == '0)));

  // Vacant entries never reported
  assert_vacant_no_hit_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_op == OP_SEARCH) |-> ((rsp_match & ~busy_vec) == '0));

  // Written slot is occupied
  assert_written_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_op == OP_WRITE && !rsp_full) |-> busy_vec[rsp_index]);

  // Full write changes nothing
  assert_full_stable_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_full |-> ($stable(busy_vec) && rsp_valid && rsp_op == OP_WRITE));

endmodule

// File: tb/cam_assoc_store_tb.sv
`timescale 1ns/1ps
module cam_assoc_store_tb;

  localparam int N  = 4;
  localparam int KW = 4;
  localparam int DW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_op;
  logic [KW-1:0] req_key;
  logic [KW-1:0] req_mask;
  logic [DW-1:0] req_data;
  logic [IW-1:0] req_index;
  logic          rsp_valid;
  logic [1:0]    rsp_op;
  logic          rsp_none, rsp_one, rsp_many, rsp_full;
  logic [IW-1:0] rsp_index;
  logic [N-1:0]  rsp_match;
  logic [DW-1:0] rsp_data;

  int n_checks = 0;
  int n_errors = 0;

  logic          m_busy [N];
  logic [KW-1:0] m_key  [N];
  logic [DW-1:0] m_data [N];

  always #2.5 clk = ~clk;

  cam_assoc_store #(.ENTRIES(N), .KEY_W(KW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_key(req_key), .req_mask(req_mask),
    .req_data(req_data), .req_index(req_index), .rsp_valid(rsp_valid),
    .rsp_op(rsp_op), .rsp_none(rsp_none), .rsp_one(rsp_one),
    .rsp_many(rsp_many), .rsp_full(rsp_full), .rsp_index(rsp_index),
    .rsp_match(rsp_match), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one request on a falling edge; return on the next falling edge,
  // where the response registered at the accepting edge is visible.
  task automatic issue(input logic [1:0] op, input logic [KW-1:0] key,
                       input logic [KW-1:0] mask, input logic [DW-1:0] data,
                       input logic [IW-1:0] idx);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_key   = key;
    req_mask  = mask;
    req_data  = data;
    req_index = idx;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic lookup(input logic [KW-1:0] key, input logic [KW-1:0] mask);
    logic [N-1:0] exp_vec;
    int cnt;
    int low;
    exp_vec = '0;
    cnt = 0;
    low = -1;
    for (int i = 0; i < N; i++) begin
      if (m_busy[i] && (((m_key[i] ^ key) & mask) == 0)) begin
        exp_vec[i] = 1'b1;
        cnt++;
        if (low < 0) low = i;
      end
    end
    issue(2'd0, key, mask, '0, '0);
    check(rsp_valid === 1'b1 && rsp_op === 2'd0, "R9", "lookup strobe", rsp_valid, 1);
    check(rsp_match === exp_vec, "R2_R10", "match vector", rsp_match, exp_vec);
    check(rsp_none === (cnt == 0), "R3", "none", rsp_none, cnt == 0);
    check(rsp_one === (cnt == 1), "R3", "one", rsp_one, cnt == 1);
    check(rsp_many === (cnt > 1), "R3", "many", rsp_many, cnt > 1);
    if (cnt > 0) begin
      check(rsp_index === IW'(low), "R4", "lowest index", rsp_index, low);
      check(rsp_data === m_data[low], "R4", "payload", rsp_data, m_data[low]);
    end
  endtask

  task automatic store(input logic [KW-1:0] key, input logic [DW-1:0] data);
    int slot;
    slot = -1;
    for (int i = 0; i < N; i++) begin
      if (!m_busy[i] && slot < 0) slot = i;
    end
    issue(2'd1, key, '0, data, '0);
    check(rsp_valid === 1'b1 && rsp_op === 2'd1, "R9", "write strobe", rsp_valid, 1);
    if (slot >= 0) begin
      check(rsp_full === 1'b0, "R5", "full on free write", rsp_full, 0);
      check(rsp_index === IW'(slot), "R5", "allocated slot", rsp_index, slot);
      m_busy[slot] = 1'b1;
      m_key[slot]  = key;
      m_data[slot] = data;
    end else begin
      check(rsp_full === 1'b1, "R6", "full flag", rsp_full, 1);
      @(negedge clk);
      check(rsp_full === 1'b0, "R6", "full single cycle", rsp_full, 0);
      check(rsp_valid === 1'b0, "R9", "strobe single cycle", rsp_valid, 0);
    end
  endtask

  task automatic release_slot(input int idx);
    issue(2'd2, '0, '0, '0, IW'(idx));
    check(rsp_valid === 1'b1 && rsp_op === 2'd2, "R8", "release strobe", rsp_valid, 1);
    check({rsp_none, rsp_one, rsp_many} === 3'b000, "R3", "status quiet on release",
          {rsp_none, rsp_one, rsp_many}, 0);
    m_busy[idx] = 1'b0;
  endtask

  task automatic sweep();
    for (int k = 0; k < (1 << KW); k++) begin
      for (int m = 0; m < (1 << KW); m++) begin
        lookup(KW'(k), KW'(m));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 1'b0;
      m_key[i]  = '0;
      m_data[i] = '0;
    end
    rst = 1'b1;
    req_valid = 1'b0;
    req_op = '0; req_key = '0; req_mask = '0; req_data = '0; req_index = '0;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b0, "R9", "ready low in reset", req_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready === 1'b1, "R9", "ready after reset", req_ready, 1);
    check(rsp_valid === 1'b0, "R1", "no strobe after reset", rsp_valid, 0);
    // R1: empty store answers none, even with all bits don't-care
    lookup(4'h0, 4'h0);
    lookup(4'h5, 4'hF);

    // R5: fill in order
    store(4'h3, 8'hA0);
    store(4'h5, 8'hA1);
    store(4'h5, 8'hA2);
    store(4'hC, 8'hA3);
    // R6: store is full
    store(4'h7, 8'hEE);
    // R6: unchanged contents
    lookup(4'h7, 4'hF);
    lookup(4'h0, 4'h0);

    // R2 R3 R4 R10: exhaustive key/mask sweep on full store
    sweep();

    // R8 R7: release entry 1, then look up its key
    release_slot(1);
    lookup(4'h5, 4'hF);
    sweep();

    // R8 R5: released slot reused
    store(4'h9, 8'hB9);
    lookup(4'h9, 4'hF);

    // R9: no-op code answered with quiet status
    issue(2'd3, '0, '0, '0, '0);
    check(rsp_valid === 1'b1 && rsp_op === 2'd3, "R9", "no-op strobe", rsp_op, 3);
    check(rsp_match === '0, "R10", "match zero on no-op", rsp_match, 0);

    // R7: release all, nothing matches
    for (int i = 0; i < N; i++) release_slot(i);
    sweep();

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule